// File: doc/BRIEF.md
# Pin I/O Controller with Edge-Triggered Interrupts

This block is a register-mapped controller for 28 general-purpose pins. Software reaches it through a plain 32-bit register port with a byte address, a write strobe with write data, and a read strobe whose data comes back registered one cycle later. For every pin there is an output-enable bit and an output latch. The latch is never written directly. One register sets latch bits and another clears them, so one pin can change without a read-modify-write.

Each pin can also watch its synchronized input level for rising transitions, falling transitions or both, each chosen per pin. A transition that is enabled sets a sticky flag in an event register. Software clears a flag by writing a 1 to its bit position. The flags of the eleven lowest pins each drive a separate interrupt line. The flags of the remaining seventeen pins are ORed onto one common line. There is also a per-pin routing-select register; the block only stores it, and logic outside the block decodes it.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous reset, every pin is an input (`pin_oe` = 0), the output latch is 0, and both edge-enable registers and the event register read 0. All interrupt outputs are low.
- R2: The output-enable register sits at byte offset 0x04. A 1 in bit n makes pin n an output on `pin_oe[n]`, and a 0 makes it an input. A read returns the written value with bits 31..28 forced to 0.
- R3: A write to offset 0x08 drives high every latch bit whose data bit is 1. Bits written as 0 keep their value. A read of this offset returns 0.
- R4: A write to offset 0x0C drives low every latch bit whose data bit is 1. Bits written as 0 keep their value. A read of this offset returns 0.
- R5: A read of offset 0x00 returns the synchronized level of all 28 pins, whatever their direction, with bits 31..28 at 0. Writes to this offset change nothing.
- R6: If bit n of the rising-enable register (offset 0x10) is set, a 0-to-1 change on pin n sets event bit n. A 1-to-0 change does not set it unless falling detection is enabled for that pin.
- R7: If bit n of the falling-enable register (offset 0x14) is set, a 1-to-0 change on pin n sets event bit n. A pin with neither enable set never raises its event bit.
- R8: A pin with both enables set flags a change in either direction.
- R9: The event register at offset 0x18 is sticky. Writing 1 to bit n clears it, and bits written as 0 keep their value. Writing all ones clears every flag.
- R10: If an enabled edge on pin n is detected in the same cycle as a write-1-to-clear of bit n, event bit n stays set.
- R11: `irq_pin[n]` equals event bit n for n = 0..10. `irq_shared` is high exactly when any event bit from 11 to 27 is set.
- R12: The routing-select register at offset 0x1C stores bits 27..0 and reads them back, with bits 31..28 at 0. It has no effect on the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address of the register |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_ren` |
| pin_in | input | 28 | Pin levels as seen at the pads |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable per pin |
| irq_pin | output | 11 | Dedicated interrupt lines for pins 0..10 |
| irq_shared | output | 1 | Common interrupt line for pins 11..27 |

## Verification
A table of register writes with readback first tests storage and the masking of the reserved bits. It uses all-ones data, sparse data and data with the top nibble set. A set followed by a partial clear shows that 0 bits leave the latch alone. The edge tests use three pins that differ in their enables: rising only, falling only, and both. The both-edges pin lies in the shared group. Each pin then sees a rise and a fall, which separates an edge that was detected from one that was ignored, and a dedicated line from the shared one. Partial clears show that the flags are sticky per bit. A clear timed to land in the same cycle as a fresh edge shows that the edge wins.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned BUS_AW = 5;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [2:0] {
    WI_LEVEL = 3'd0,
    WI_OE    = 3'd1,
    WI_SET   = 3'd2,
    WI_CLR   = 3'd3,
    WI_RISE  = 3'd4,
    WI_FALL  = 3'd5,
    WI_EVENT = 3'd6,
    WI_ROUTE = 3'd7
  } word_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr,
  output logic hit,
  output logic flag
);
  logic prev_q;

  // An edge is a difference between the synchronized level and its value one cycle earlier.
  assign hit = (rise_en & level & ~prev_q) | (fall_en & ~level & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= level;
      // A new edge overrides a clear in the same cycle.
      flag   <= (flag & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_wen,
  input  logic [BUS_DW-1:0]  bus_wdata,
  input  logic               bus_ren,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   level,
  input  logic [NPINS-1:0]   flags,
  output logic [NPINS-1:0]   oe_q,
  output logic [NPINS-1:0]   out_q,
  output logic [NPINS-1:0]   rise_q,
  output logic [NPINS-1:0]   fall_q,
  output logic [NPINS-1:0]   flag_clr
);
  localparam int unsigned PAD = BUS_DW - NPINS;

  logic [NPINS-1:0] route_q;
  word_idx_e        widx;
  logic             aligned;
  logic [NPINS-1:0] wpins;
  logic             w_oe, w_set, w_clr, w_rise, w_fall, w_evt, w_route;
  logic [NPINS-1:0] rd_mux;

  assign widx    = word_idx_e'(bus_addr[BUS_AW-1:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wpins   = bus_wdata[NPINS-1:0];

  assign w_oe    = bus_wen & aligned & (widx == WI_OE);
  assign w_set   = bus_wen & aligned & (widx == WI_SET);
  assign w_clr   = bus_wen & aligned & (widx == WI_CLR);
  assign w_rise  = bus_wen & aligned & (widx == WI_RISE);
  assign w_fall  = bus_wen & aligned & (widx == WI_FALL);
  assign w_evt   = bus_wen & aligned & (widx == WI_EVENT);
  assign w_route = bus_wen & aligned & (widx == WI_ROUTE);

  assign flag_clr = w_evt ? wpins : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= '0;
      out_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      route_q <= '0;
    end else begin
      if (w_oe)    oe_q    <= wpins;
      if (w_rise)  rise_q  <= wpins;
      if (w_fall)  fall_q  <= wpins;
      if (w_route) route_q <= wpins;
      // Set is applied after clear so it dominates.
      out_q <= (out_q & ~(w_clr ? wpins : '0)) | (w_set ? wpins : '0);
    end
  end

  always_comb begin
    unique case (widx)
      WI_LEVEL: rd_mux = level;
      WI_OE:    rd_mux = oe_q;
      WI_RISE:  rd_mux = rise_q;
      WI_FALL:  rd_mux = fall_q;
      WI_EVENT: rd_mux = flags;
      WI_ROUTE: rd_mux = route_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_ren) begin
      bus_rdata <= aligned ? {{PAD{1'b0}}, rd_mux} : '0;
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 28,
  parameter int unsigned NDED  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_wen,
  input  logic [BUS_DW-1:0]  bus_wdata,
  input  logic               bus_ren,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NDED-1:0]    irq_pin,
  output logic               irq_shared
);
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] flags;
  logic [NPINS-1:0] hits;
  logic [NPINS-1:0] rise_q, fall_q, flag_clr;
  logic [NPINS-1:0] flags_next;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(level)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .level(level), .flags(flags),
    .oe_q(pin_oe), .out_q(pin_out),
    .rise_q(rise_q), .fall_q(fall_q), .flag_clr(flag_clr)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_edge_cell u_cell (
      .clk(clk), .rst(rst),
      .level(level[p]), .rise_en(rise_q[p]), .fall_en(fall_q[p]),
      .clr(flag_clr[p]), .hit(hits[p]), .flag(flags[p])
    );
  end

  // The interrupt lines are registered from the next flag value, so they stay in step with the flags.
  assign flags_next = (flags & ~flag_clr) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin    <= '0;
      irq_shared <= 1'b0;
    end else begin
      irq_pin    <= flags_next[NDED-1:0];
      irq_shared <= |flags_next[NPINS-1:NDED];
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 28,
  parameter int unsigned NDED  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wen,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  flags,
  input logic [NDED-1:0]   irq_pin,
  input logic              irq_shared
);
  logic wr_set, wr_clr, wr_oe, wr_evt;
  assign wr_set = bus_wen && bus_addr == 5'h08;
  assign wr_clr = bus_wen && bus_addr == 5'h0C;
  assign wr_oe  = bus_wen && bus_addr == 5'h04;
  assign wr_evt = bus_wen && bus_addr == 5'h18;

  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  a_r4_clr_drives_low: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_oe |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> ((flags & $past(flags)) == $past(flags)));

  a_r11_irq_match: assert property (@(posedge clk) disable iff (rst)
    (irq_pin == flags[NDED-1:0]) && (irq_shared == (|flags[NPINS-1:NDED])));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .NDED(NDED)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .flags(flags), .irq_pin(irq_pin), .irq_shared(irq_shared)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] pin_out, pin_oe;
  logic [10:0] irq_pin;
  logic        irq_shared;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  localparam logic [4:0] A_LVL = 5'h00, A_OE = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C,
                         A_RISE = 5'h10, A_FALL = 5'h14, A_EVT = 5'h18, A_ROUTE = 5'h1C;

  // address, write data, expected readback
  localparam int NVEC = 12;
  localparam logic [68:0] VEC [NVEC] = '{
    {A_OE,    32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {A_OE,    32'h0000_00A5, 32'h0000_00A5},
    {A_RISE,  32'hF123_4567, 32'h0123_4567},
    {A_FALL,  32'h0ABC_DEF0, 32'h0ABC_DEF0},
    {A_ROUTE, 32'h5555_5555, 32'h0555_5555},
    {A_ROUTE, 32'hF000_0001, 32'h0000_0001},
    {A_SET,   32'h0000_000F, 32'h0000_0000},
    {A_CLR,   32'h0000_0003, 32'h0000_0000},
    {A_LVL,   32'h0FFF_FFFF, 32'h0000_0000},
    {A_RISE,  32'h0000_0000, 32'h0000_0000},
    {A_FALL,  32'h0000_0000, 32'h0000_0000},
    {A_OE,    32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [27:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_irq(input string req, input logic [27:0] flg);
    check(req, {20'd0, irq_pin, irq_shared}, {20'd0, flg[10:0], |flg[27:11]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [27:0] en_r, en_f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", {4'd0, pin_oe}, 32'd0);
    check("R1 out", {4'd0, pin_out}, 32'd0);
    check_irq("R1 irq", 28'd0);
    bus_read(A_RISE, rd);  check("R1 rise", rd, 32'd0);
    bus_read(A_FALL, rd);  check("R1 fall", rd, 32'd0);
    bus_read(A_EVT, rd);   check("R1 event", rd, 32'd0);

    // Register table: R2 R3 R4 R5 R12 storage and masking
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][68:64], VEC[i][63:32]);
      bus_read(VEC[i][68:64], rd);
      check("R2/R3/R4/R5/R12 table readback", rd, VEC[i][31:0]);
      if (VEC[i][68:64] == A_OE)
        check("R2 pin_oe", {4'd0, pin_oe}, VEC[i][31:0]);
    end
    // R3 then R4: set 0xF then clear 0x3, zero bits kept
    check("R3/R4 latch", {4'd0, pin_out}, 32'h0000_000C);
    bus_write(A_SET, 32'h0800_0100);
    check("R3 set keeps others", {4'd0, pin_out}, 32'h0800_010C);
    bus_write(A_CLR, 32'h0000_0008);
    check("R4 clear keeps others", {4'd0, pin_out}, 32'h0800_0104);
    check("R12 route no effect", {4'd0, pin_oe}, 32'd0);

    // R5 level, mixed directions
    bus_write(A_OE, 32'h0000_FFFF);
    drive_pins(28'hABC_DE5A);
    bus_read(A_LVL, rd); check("R5 level", rd, 32'h0ABC_DE5A);
    drive_pins(28'd0);
    bus_read(A_LVL, rd); check("R5 level zero", rd, 32'd0);
    bus_read(A_EVT, rd); check("R7 no enables no flags", rd, 32'd0);

    // Edge tests: pin2 rise only (R6), pin5 fall only (R7), pin20 both (R8)
    en_r = (28'd1 << 2) | (28'd1 << 20);
    en_f = (28'd1 << 5) | (28'd1 << 20);
    bus_write(A_RISE, {4'd0, en_r});
    bus_write(A_FALL, {4'd0, en_f});
    drive_pins((28'd1 << 2) | (28'd1 << 5) | (28'd1 << 20) | (28'd1 << 7));
    bus_read(A_EVT, rd); check("R6/R8 rising flags", rd, 32'h0010_0004);
    check_irq("R11 irq after rise", 28'h010_0004);
    bus_write(A_EVT, 32'hFFFF_FFFF);
    bus_read(A_EVT, rd); check("R9 clear all", rd, 32'd0);
    check_irq("R11 irq cleared", 28'd0);
    drive_pins(28'd0);
    bus_read(A_EVT, rd); check("R7/R8 falling flags", rd, 32'h0010_0020);
    check_irq("R11 irq after fall", 28'h010_0020);
    bus_write(A_EVT, 32'h0000_0020);
    bus_read(A_EVT, rd); check("R9 partial clear sticky", rd, 32'h0010_0000);
    check_irq("R11 shared only", 28'h010_0000);
    bus_write(A_EVT, 32'h0010_0000);
    bus_read(A_EVT, rd); check("R9 cleared", rd, 32'd0);

    // R10: edge and clear in the same cycle
    drive_pins(28'd1 << 20);
    bus_read(A_EVT, rd); check("R8 pin20 rise", rd, 32'h0010_0000);
    @(negedge clk);
    pin_in = 28'd0;            // sync stage 1 at next edge, stage 2 the one after
    @(negedge clk);
    bus_write(A_EVT, 32'h0010_0000); // write sampled in the cycle the fall is seen
    bus_read(A_EVT, rd); check("R10 edge beats clear", rd, 32'h0010_0000);
    bus_write(A_EVT, 32'h0010_0000);
    bus_read(A_EVT, rd); check("R10 later clear works", rd, 32'd0);

    // R1 again after a mid-run reset
    bus_write(A_SET, 32'h0000_00FF);
    bus_write(A_OE, 32'h0000_00FF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 oe after reset", {4'd0, pin_oe}, 32'd0);
    check("R1 out after reset", {4'd0, pin_out}, 32'd0);
    bus_read(A_RISE, rd); check("R1 rise after reset", rd, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule